// File: doc/BRIEF.md
# Host Channel Interrupt Aggregator

This block collects interrupt events from up to sixteen host channels and a small set of core-level sources, and reduces them to a single registered interrupt line for a processor. Each channel keeps a vector of sticky cause bits and a mask vector of the same width. A channel's summary bit is pending when any of its unmasked causes is set. The summary vector has its own mask, and the masked summaries merge into one channel-pending bit in the core status word. That word also holds the sticky core-level sources. A core mask and a global enable then decide whether the output line rises.

Software reaches every register through a flat word interface with a write strobe and an address. Read data is registered and shows the addressed register one cycle after the address is presented. Events always land in the status bits, whatever the masks say. Software clears causes only at the channel level, by writing one to them, and the summary and channel-pending bits follow from those causes. In every mask a 1 unmasks and a 0 masks.

Top module: `usbh_irq_agg`

## Requirements
- R1: An event pulse on cause bit i of channel c sets that cause bit on the next clock, whatever the masks and the global enable hold. Channel c's cause word reads at address 0x20+c, with cause i at bit i.
- R2: A write to address 0x20+c clears each cause bit of channel c whose write-data bit is 1. Bits written as 0 keep their value.
- R3: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Summary bit c (address 0x03, bit c) reads 1 exactly when channel c has a cause bit that is set and unmasked. Channel c's mask is RW at 0x30+c, 1 = unmask. A write to 0x03 has no effect on the summary bits.
- R5: The channel-pending bit, at bit NUM_SRC of the core status word (address 0x00), reads 1 exactly when a summary bit is set whose summary-mask bit (address 0x04, 1 = unmask) is 1. Writing 1 to that bit does not clear it.
- R6: Core source events set core status bits [NUM_SRC-1:0] on the next clock. Writing 1 to one of these bits at 0x00 clears it, writing 0 leaves it alone, and an event in the same cycle wins over the clear.
- R7: The core mask (0x01, same bit layout as the core status word, 1 = unmask) and the global enable (0x02, bit 0) are read/write. Status bits update whatever the global enable holds.
- R8: The output irq is registered. On each clock it takes global enable AND (OR of core status AND core mask), using the register values from before that clock. It therefore deasserts one cycle after the last unmasked pending bit is cleared.
- R9: After synchronous reset, all status, mask, enable and read-data registers are 0, and irq is 0.
- R10: reg_rdata takes the value of the register at reg_addr one clock after that address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_event | input | NUM_CH*NUM_CAUSE | Per-channel cause event pulses; channel c occupies bits [c*NUM_CAUSE +: NUM_CAUSE] |
| core_event | input | NUM_SRC | Core-level source event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt line |

## Verification
A wrong cause, mask or summary bit shows up at the ports in two ways. On reg_rdata it appears one clock after the affected address is read. On irq it appears one clock after the bad state reaches the core status word, as long as the masks and the global enable let it through. The reference model tracks every register and predicts both outputs for every cycle, so a bad bit that sits behind a mask is still caught as soon as it is read back. The directed part covers the exact set-versus-clear collision, the write-one-to-clear of the derived pending bit, and the single-cycle lag of irq after a clear. A random phase mixes events, mask writes and clears across all channels.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int MAX_CH = 16;

  localparam logic [ADDR_W-1:0] A_CORE_STAT  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CORE_MASK  = 6'h01;
  localparam logic [ADDR_W-1:0] A_GLB_EN     = 6'h02;
  localparam logic [ADDR_W-1:0] A_SUMM       = 6'h03;
  localparam logic [ADDR_W-1:0] A_SUMM_MASK  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CAUSE_BASE = 6'h20;
  localparam logic [ADDR_W-1:0] A_CMASK_BASE = 6'h30;

  function automatic logic [ADDR_W-1:0] ch_addr(input logic [ADDR_W-1:0] base, input int idx);
    return base | ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/usbh_ch_cause.sv
module usbh_ch_cause #(
  parameter int NUM_CAUSE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE-1:0] ev,
  input  logic                 wr_cause,
  input  logic                 wr_mask,
  input  logic [NUM_CAUSE-1:0] wdata,
  output logic [NUM_CAUSE-1:0] cause_q,
  output logic [NUM_CAUSE-1:0] mask_q,
  output logic                 summ
);
  logic [NUM_CAUSE-1:0] clr;

  assign clr  = wr_cause ? wdata : '0;
  assign summ = |(cause_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & ~clr) | ev;
      if (wr_mask) mask_q <= wdata;
    end
  end

  // R1: every event bit is visible as set on the next clock
  p_cause_set_r1: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((cause_q & $past(ev)) == $past(ev)));

  // R2: a clear write drops exactly the written-one bits when no event arrives
  p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_cause && ev == '0) |=> (cause_q == ($past(cause_q) & ~$past(wdata))));

  // R3: collision of set and clear keeps the bit set
  p_set_beats_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_cause && ((ev & wdata) != '0)) |=> ((cause_q & $past(ev & wdata)) == $past(ev & wdata)));
endmodule

// File: rtl/usbh_core_stat.sv
module usbh_core_stat #(
  parameter int NUM_SRC = 6,
  localparam int CW = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ev,
  input  logic               ch_pend,
  input  logic               wr_stat,
  input  logic               wr_mask,
  input  logic               wr_glb,
  input  logic [CW-1:0]      wdata,
  output logic [NUM_SRC-1:0] stat_q,
  output logic [CW-1:0]      mask_q,
  output logic               glb_q,
  output logic               line_q
);
  logic [NUM_SRC-1:0] clr;
  logic [CW-1:0]      full;
  logic               hit;

  assign clr  = wr_stat ? wdata[NUM_SRC-1:0] : '0;
  assign full = {ch_pend, stat_q};
  assign hit  = |(full & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      glb_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | ev;
      if (wr_mask) mask_q <= wdata;
      if (wr_glb)  glb_q  <= wdata[0];
      line_q <= glb_q & hit;
    end
  end

  // R6: sticky bits only fall on a status write
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: global enable off forces the line low on the next clock
  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !glb_q |=> !line_q);

  // R8: nothing unmasked pending means the line is low one clock later
  p_line_drop_r8: assert property (@(posedge clk) disable iff (rst)
    ((full & mask_q) == '0) |=> !line_q);
endmodule

// File: rtl/usbh_irq_agg.sv
module usbh_irq_agg
  import usbh_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_CAUSE = 8,
  parameter int NUM_SRC   = 6,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH*NUM_CAUSE-1:0]   ch_event,
  input  logic [NUM_SRC-1:0]            core_event,
  input  logic                          reg_we,
  input  logic [5:0]                    reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          irq
);
  localparam int CW = NUM_SRC + 1;

  initial begin
    a_cfg: assert (NUM_CH <= MAX_CH && NUM_CH <= DATA_W && NUM_CAUSE <= DATA_W && CW <= DATA_W)
      else $error("usbh_irq_agg: parameter out of range");
  end

  logic [NUM_CAUSE-1:0] cause_arr [NUM_CH];
  logic [NUM_CAUSE-1:0] cmask_arr [NUM_CH];
  logic [NUM_CH-1:0]    summ;
  logic [NUM_CH-1:0]    smask_q;
  logic                 ch_pend;
  logic [NUM_SRC-1:0]   core_stat;
  logic [CW-1:0]        core_mask;
  logic                 glb_en;
  logic [DATA_W-1:0]    rd_nx;
  logic [DATA_W-1:0]    rd_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_c, wr_m;
    assign wr_c = reg_we && (reg_addr == ch_addr(A_CAUSE_BASE, c));
    assign wr_m = reg_we && (reg_addr == ch_addr(A_CMASK_BASE, c));

    usbh_ch_cause #(.NUM_CAUSE(NUM_CAUSE)) i_ch (
      .clk      (clk),
      .rst      (rst),
      .ev       (ch_event[c*NUM_CAUSE +: NUM_CAUSE]),
      .wr_cause (wr_c),
      .wr_mask  (wr_m),
      .wdata    (reg_wdata[NUM_CAUSE-1:0]),
      .cause_q  (cause_arr[c]),
      .mask_q   (cmask_arr[c]),
      .summ     (summ[c])
    );
  end

  assign ch_pend = |(summ & smask_q);

  always_ff @(posedge clk) begin
    if (rst) smask_q <= '0;
    else if (reg_we && reg_addr == A_SUMM_MASK) smask_q <= reg_wdata[NUM_CH-1:0];
  end

  usbh_core_stat #(.NUM_SRC(NUM_SRC)) i_core (
    .clk     (clk),
    .rst     (rst),
    .ev      (core_event),
    .ch_pend (ch_pend),
    .wr_stat (reg_we && reg_addr == A_CORE_STAT),
    .wr_mask (reg_we && reg_addr == A_CORE_MASK),
    .wr_glb  (reg_we && reg_addr == A_GLB_EN),
    .wdata   (reg_wdata[CW-1:0]),
    .stat_q  (core_stat),
    .mask_q  (core_mask),
    .glb_q   (glb_en),
    .line_q  (irq)
  );

  always_comb begin
    rd_nx = '0;
    if (reg_addr == A_CORE_STAT) rd_nx[CW-1:0] = {ch_pend, core_stat};
    if (reg_addr == A_CORE_MASK) rd_nx[CW-1:0] = core_mask;
    if (reg_addr == A_GLB_EN)    rd_nx[0]      = glb_en;
    if (reg_addr == A_SUMM)      rd_nx[NUM_CH-1:0] = summ;
    if (reg_addr == A_SUMM_MASK) rd_nx[NUM_CH-1:0] = smask_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ch_addr(A_CAUSE_BASE, c)) rd_nx[NUM_CAUSE-1:0] = cause_arr[c];
      if (reg_addr == ch_addr(A_CMASK_BASE, c)) rd_nx[NUM_CAUSE-1:0] = cmask_arr[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nx;
  end
  assign reg_rdata = rd_q;

  // R4: without any register write, no summary bit can fall
  p_summ_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> (($past(summ) & ~summ) == '0));

  // R5: pending bit at core level implies an unmasked summary in the channel tree
  p_pend_src_r5: assert property (@(posedge clk) disable iff (rst)
    (smask_q == '0) |-> !i_core.full[NUM_SRC]);

  // R9: read data is zero right after reset
  p_rd_after_rst_r9: assert property (@(posedge clk)
    $past(rst) |-> (reg_rdata == '0 && !irq));
endmodule

// File: tb/test_usbh_irq_agg.sv
`timescale 1ns/1ps
module test_usbh_irq_agg;
  localparam int NCH = 16;
  localparam int NCA = 8;
  localparam int NS  = 6;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH*NCA-1:0] ch_ev = '0;
  logic [NS-1:0] core_ev = '0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  always #4 clk = ~clk;

  usbh_irq_agg #(.NUM_CH(NCH), .NUM_CAUSE(NCA), .NUM_SRC(NS), .DATA_W(DW)) i_usbh_irq_agg (
    .clk(clk), .rst(rst), .ch_event(ch_ev), .core_event(core_ev),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  // reference state
  bit [NCA-1:0] m_cause [NCH];
  bit [NCA-1:0] m_cmask [NCH];
  bit [NCH-1:0] m_smask;
  bit [NS-1:0]  m_st;
  bit [NS:0]    m_cmk;
  bit           m_glb;
  bit [DW-1:0]  exp_rd;
  bit           exp_irq;

  function automatic bit [NCH-1:0] m_summ();
    bit [NCH-1:0] s = '0;
    for (int c = 0; c < NCH; c++) s[c] = (m_cause[c] & m_cmask[c]) != 0;
    return s;
  endfunction

  function automatic bit m_pend();
    return (m_summ() & m_smask) != 0;
  endfunction

  function automatic bit [DW-1:0] m_read(input int a);
    bit [DW-1:0] v = '0;
    if (a == 0) v[NS:0] = {m_pend(), m_st};
    else if (a == 1) v[NS:0] = m_cmk;
    else if (a == 2) v[0] = m_glb;
    else if (a == 3) v[NCH-1:0] = m_summ();
    else if (a == 4) v = m_smask;
    else if (a >= 32 && a < 32 + NCH) v[NCA-1:0] = m_cause[a-32];
    else if (a >= 48 && a < 48 + NCH) v[NCA-1:0] = m_cmask[a-48];
    return v;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  // one clock: predict, update model, advance, compare
  task automatic step();
    bit [DW-1:0] nrd;
    bit nirq;
    if (rst) begin
      nrd = '0; nirq = 1'b0;
      for (int c = 0; c < NCH; c++) begin m_cause[c] = '0; m_cmask[c] = '0; end
      m_smask = '0; m_st = '0; m_cmk = '0; m_glb = 1'b0;
    end else begin
      nrd  = m_read(int'(addr));
      nirq = m_glb & (({m_pend(), m_st} & m_cmk) != 0);
      for (int c = 0; c < NCH; c++) begin
        bit [NCA-1:0] clr = (we && addr == 6'(32 + c)) ? wdata[NCA-1:0] : '0;
        m_cause[c] = (m_cause[c] & ~clr) | ch_ev[c*NCA +: NCA];
        if (we && addr == 6'(48 + c)) m_cmask[c] = wdata[NCA-1:0];
      end
      m_st = (m_st & ~((we && addr == 6'd0) ? wdata[NS-1:0] : '0)) | core_ev;
      if (we && addr == 6'd1) m_cmk = wdata[NS:0];
      if (we && addr == 6'd2) m_glb = wdata[0];
      if (we && addr == 6'd4) m_smask = wdata;
    end
    exp_rd = nrd; exp_irq = nirq;
    @(posedge clk);
    @(negedge clk);
    ch_ev = '0; core_ev = '0; we = 1'b0;
    check("R10 rdata", int'(rdata), int'(exp_rd));
    check("R8 irq", int'(irq), int'(exp_irq));
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 6'(a); wdata = DW'(d);
    step();
  endtask

  task automatic rd(input int a, output int v);
    addr = 6'(a);
    step();
    v = int'(rdata);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    check("R9 irq after reset", int'(irq), 0);
    check("R9 rdata after reset", int'(rdata), 0);
    rst = 1'b0;
    rd(0, v); check("R9 core status reset", v, 0);
    rd(1, v); check("R9 core mask reset", v, 0);
    rd(4, v); check("R9 summary mask reset", v, 0);

    // R1: event lands despite all masks closed
    ch_ev[3*NCA + 2] = 1'b1; step();
    rd(32 + 3, v); check("R1 cause set masked", v, 'h04);
    rd(3, v); check("R4 summary masked off", v, 0);
    check("R1 irq stays low", int'(irq), 0);

    // R4/R5 mask chain
    wr(48 + 3, 'h04);
    rd(3, v); check("R4 summary follows cause&mask", v, 'h0008);
    rd(0, v); check("R5 pending needs summary mask", v, 0);
    wr(4, 'h0008);
    rd(0, v); check("R5 pending set", v, 1 << NS);
    wr(0, 1 << NS);
    rd(0, v); check("R5 pending not cleared by W1C", v, 1 << NS);
    wr(3, 'h0000);
    rd(3, v); check("R4 summary write ignored", v, 'h0008);

    // R7/R8 line
    wr(1, 1 << NS);
    rd(1, v); check("R7 core mask readback", v, 1 << NS);
    wr(2, 1);
    step();
    check("R8 irq asserted", int'(irq), 1);

    // R2: zero write no effect, one write clears, irq one cycle later
    wr(32 + 3, 'h00);
    rd(32 + 3, v); check("R2 zero write keeps cause", v, 'h04);
    wr(32 + 3, 'h04);
    check("R8 irq still high in clear cycle", int'(irq), 1);
    step();
    check("R8 irq drops one cycle after clear", int'(irq), 0);
    rd(0, v); check("R5 pending follows cause clear", v, 0);

    // R3 collision on channel 5
    ch_ev[5*NCA + 1] = 1'b1; wr(32 + 5, 'h02);
    rd(32 + 5, v); check("R3 set beats clear", v, 'h02);

    // R6 core sticky sources
    core_ev = 6'b000100; step();
    rd(0, v); check("R6 core source set", v, 'h04);
    wr(0, 'h00);
    rd(0, v); check("R6 zero write keeps", v, 'h04);
    core_ev = 6'b000100; wr(0, 'h04);
    rd(0, v); check("R6 set beats clear", v, 'h04);
    wr(0, 'h04);
    rd(0, v); check("R6 W1C clears", v, 0);

    // R7 global enable off: status still updates, line low
    wr(1, 'h7F); wr(2, 0);
    core_ev = 6'b100000; step(); step();
    check("R7 enable off keeps irq low", int'(irq), 0);
    rd(0, v); check("R7 status updates when disabled", v, 'h20);
    wr(2, 1); step();
    check("R8 irq after re-enable", int'(irq), 1);

    // random mix, model compared every clock
    for (int n = 0; n < 2000; n++) begin
      int r;
      for (int c = 0; c < NCH; c++)
        ch_ev[c*NCA +: NCA] = NCA'($urandom & $urandom & $urandom & $urandom);
      core_ev = NS'($urandom & $urandom & $urandom);
      r = int'($urandom % 6);
      if (r == 0) addr = 6'($urandom % 5);
      else if (r < 3) addr = 6'(32 + $urandom % NCH);
      else if (r < 5) addr = 6'(48 + $urandom % NCH);
      else addr = 6'($urandom % 64);
      we = ($urandom % 3) == 0;
      wdata = DW'($urandom);
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule